// File: doc/BRIEF.md
# Indirect PHY Register Access Window

This block is a single 32-bit memory-mapped window through which software reaches the byte-wide register space of a low-pin-count USB transceiver. The transceiver register space is modelled inside the block as a 256-byte array. Software writes the window word to set up an access. The word holds a target register address, a byte to store, a read/write select and a start flag. The block carries out the access in the same clock. It then clears the start flag, and any fetched byte is left in a read-only lane of the word.

Software starts an access by writing the word with the start flag set. It reads the word back on the next bus cycle, sees the start flag low, and takes the result from the read lane. The word also carries a port selector and a wakeup request. The wakeup request is dropped as soon as the write that set it has been handled. A link-state flag is always reported as set.

Top module: `ulpi_window`

## Requirements
- R1: After reset the window word reads 0x0800_0000. Only the link-state flag at bit 27 is set.
- R2: After reset the register space holds 0x24 at address 0x00, 0x04 at 0x01, 0x04 at 0x02 and 0x00 at 0x03. Every other address holds 0x00.
- R3: An accepted write changes only these bits: the write byte at [7:0], the address at [23:16], the port at [26:24], the read/write select at bit 29, the start flag at bit 30 and the wakeup request at bit 31. The read lane [15:8], the link-state flag at bit 27 and bit 28 keep their values.
- R4: After any accepted write, the wakeup request at bit 31 reads 0.
- R5: An accepted write with bit 30 = 1 and bit 29 = 1 stores the write byte [7:0] into the register at address [23:16]. The read lane is left unchanged.
- R6: An accepted write with bit 30 = 1 and bit 29 = 0 loads the register at address [23:16] into the read lane [15:8].
- R7: After a started access, bit 30 reads 0 on the next clock, and the result is already visible at that point.
- R8: Without an accepted write, the window word holds its value. Reading has no side effect.
- R9: A write whose four byte enables are not all set is ignored.
- R10: All 256 addresses can be written and read back. This includes the scratch byte at 0x16 and the top address 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the window word |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Current window word |

## Verification
Two things can happen in one clock: the wakeup request is dropped, and a started register access is carried out. The bench provokes this with writes that set bit 31 and bit 30 together, once for a fetch and once for a store. For each such write it compares the whole word read back on the next cycle. In that word the wakeup request and the start flag must both be low. A fetch must also show the fetched byte in the read lane. A store must leave the read lane alone, and a later fetch from the same address must return the stored byte.

// File: rtl/ulpi_window_pkg.sv
package ulpi_window_pkg;

    typedef struct packed {
        logic       wake;   // 31
        logic       start;  // 30
        logic       wr_sel; // 29
        logic       rsvd;   // 28
        logic       link;   // 27
        logic [2:0] port;   // 26:24
        logic [7:0] addr;   // 23:16
        logic [7:0] rbyte;  // 15:8
        logic [7:0] wbyte;  // 7:0
    } win_word_t;

    localparam logic [31:0] WIN_SW_MASK  = 32'hE7FF_00FF;
    localparam logic [31:0] WIN_RST_WORD = 32'h0800_0000;

endpackage

// File: rtl/win_merge.sv
module win_merge
    import ulpi_window_pkg::*;
(
    input  win_word_t   cur_word,
    input  logic [31:0] wr_data,
    output win_word_t   merged
);
    always_comb begin
        merged = win_word_t'((32'(cur_word) & ~WIN_SW_MASK) | (wr_data & WIN_SW_MASK));
    end
endmodule

// File: rtl/phy_reg_space.sv
module phy_reg_space #(
    parameter int          AW      = 8,
    parameter int          DW      = 8,
    parameter logic [7:0]  VID_LO  = 8'h24,
    parameter logic [7:0]  VID_HI  = 8'h04,
    parameter logic [7:0]  PID_LO  = 8'h04,
    parameter logic [7:0]  PID_HI  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    function automatic logic [DW-1:0] init_val(input int idx);
        case (idx)
            0:       init_val = DW'(VID_LO);
            1:       init_val = DW'(VID_HI);
            2:       init_val = DW'(PID_LO);
            3:       init_val = DW'(PID_HI);
            default: init_val = '0;
        endcase
    endfunction

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= init_val(g);
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata = mem_q[raddr];

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata))); // R5
    AST_NO_STRAY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && raddr == $past(raddr) && !$past(we)) |-> $stable(rdata)); // R8
endmodule

// File: rtl/ulpi_window.sv
module ulpi_window
    import ulpi_window_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int BE_W  = BUS_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [BE_W-1:0]  bus_be,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int PHY_AW = 8;
    localparam int PHY_DW = 8;

    typedef struct packed {
        win_word_t word;
    } state_t;

    state_t            st_d, st_q;
    win_word_t         merged;
    logic              accept;
    logic              phy_we;
    logic [PHY_DW-1:0] phy_rdata;

    win_merge u_merge (
        .cur_word (st_q.word),
        .wr_data  (bus_wdata[31:0]),
        .merged   (merged)
    );

    phy_reg_space #(.AW(PHY_AW), .DW(PHY_DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (phy_we),
        .waddr (merged.addr),
        .wdata (merged.wbyte),
        .raddr (merged.addr),
        .rdata (phy_rdata)
    );

    assign accept = bus_wr && (bus_be == {BE_W{1'b1}});

    always_comb begin
        st_d   = st_q;
        phy_we = 1'b0;
        if (accept) begin
            st_d.word = merged;
            if (merged.start) begin
                if (merged.wr_sel) phy_we = 1'b1;
                else               st_d.word.rbyte = phy_rdata;
                st_d.word.start = 1'b0;
            end
            st_d.word.wake = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.word <= win_word_t'(WIN_RST_WORD);
        else        st_q      <= st_d;
    end

    assign bus_rdata = BUS_W'(st_q.word);

    AST_WAKE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !bus_rdata[31]); // R4
    AST_START_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !bus_rdata[30]); // R7
    AST_LINK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> bus_rdata[27] && !bus_rdata[28]); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(bus_rdata)); // R8
    AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be != {BE_W{1'b1}}) |=> $stable(bus_rdata)); // R9
    AST_FETCH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_wdata[30] && !bus_wdata[29]) |=> bus_rdata[15:8] == $past(phy_rdata)); // R6
endmodule

// File: tb/test_ulpi_window.sv
module test_ulpi_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ulpi_window i_ulpi_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    localparam int NV = 12;
    localparam logic [31:0] V_DATA [NV] = '{
        32'h4000_0000, 32'h4001_0000, 32'h6016_005A, 32'h4016_0000,
        32'h85AB_00CC, 32'h1000_FF00, 32'h4002_0000, 32'hC002_0000,
        32'hE003_0077, 32'h4003_0000, 32'h60FF_003C, 32'h40FF_0000};
    localparam logic [3:0] V_BE [NV] = '{
        4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'h7, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF};
    localparam logic [31:0] V_EXP [NV] = '{
        32'h0800_2400, // R2 R6 fetch vendor low
        32'h0801_0400, // R2 R6 fetch vendor high
        32'h2816_045A, // R5 R10 store scratch, read lane kept
        32'h0816_5A00, // R10 fetch scratch
        32'h0DAB_5ACC, // R3 R4 plain write with wakeup
        32'h0800_5A00, // R3 read-only bits untouched
        32'h0800_5A00, // R9 partial enables ignored
        32'h0802_0400, // R4 R7 wakeup and fetch together
        32'h2803_0477, // R4 R5 wakeup and store together
        32'h0803_7700, // R5 R7 stored byte fetched back
        32'h28FF_773C, // R10 store top address
        32'h08FF_3C00  // R10 fetch top address
    };
    localparam logic [23:0] V_TAG [NV] = '{
        "R6 ", "R2 ", "R5 ", "R10", "R4 ", "R3 ", "R9 ", "R7 ", "R4 ", "R5 ", "R10", "R10"};

    task automatic check(input logic [31:0] exp, input string tag);
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, bus_rdata, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(32'h0800_0000, "R1 reset word");

        for (int i = 0; i < NV; i++) begin
            wr(V_DATA[i], V_BE[i]);
            check(V_EXP[i], $sformatf("%s row %0d", V_TAG[i], i));
        end

        // R8: idle cycles and reads leave the word alone
        repeat (5) @(negedge clk);
        check(32'h08FF_3C00, "R8 idle hold");

        // R7: back-to-back starts on consecutive cycles
        @(negedge clk);
        bus_wr = 1'b1; bus_be = 4'hF; bus_wdata = 32'h6040_0011;
        @(negedge clk);
        check(32'h2840_3C11, "R7 first of pair");
        bus_wdata = 32'h4040_0000;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
        check(32'h0840_1100, "R7 second of pair");

        // R9: zero enables ignored too
        wr(32'hFFFF_FFFF, 4'h0);
        check(32'h0840_1100, "R9 no enables");

        // R1 R2: reset restores word and register contents
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(32'h0800_0000, "R1 after reset");
        wr(32'h4016_0000, 4'hF);
        check(32'h0816_0000, "R2 scratch cleared");
        wr(32'h4003_0000, 4'hF);
        check(32'h0803_0000, "R2 product high restored");
        wr(32'h4002_0000, 4'hF);
        check(32'h0802_0400, "R2 product low");

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule